// File: doc/BRIEF.md
# Control-Port Transaction Sequencer

This block drives a 16-bit parallel control-register port with no software in the loop. It accepts one command at a time: either a single-register write or a burst read. For each command it produces the chain of handshake phases the port target expects. Each phase raises one of four strobes and waits for the target's acknowledge to go high. It then drops the strobe and waits for the acknowledge to go low.

A write places the offset on the shared output bus and captures it. It then presents the data and captures it, and finally commits it. A read captures the offset and then runs a read phase, sampling the target's data while the acknowledge is high. A burst repeats the offset and read phases for each consecutive register. Every word read comes back on a valid/data stream, tagged with its offset.

A command ends with a one-cycle `done` pulse, or with a one-cycle `err` pulse and the offending offset. An error occurs when the command is illegal, or when an acknowledge edge fails to arrive within the timeout.

Top module: `crport_seq`

## Requirements
- R1: Only one strobe is high at a time. Each strobe stays high until the synchronized acknowledge is seen high, unless a timeout ends the phase. The next phase starts only after the acknowledge has been seen low. Strobe coding by phase: `cr_cap_addr` = offset, `cr_cap_data` = data, `cr_write` = commit, `cr_read` = read.
- R2: A write runs the offset phase (`cr_dout` = offset), then the data phase (`cr_dout` = write data), then the commit phase. It changes exactly one register, at `cmd_base`, and ends with one `done` pulse.
- R3: A read runs the offset phase and then the read phase. `cr_din` is captured while the acknowledge is high and returned on `rsp_data`, with `rsp_offset` equal to the register's offset.
- R4: A burst read of count N returns N responses with offsets `cmd_base` to `cmd_base`+N-1 in ascending order. Each register gets its own offset and read phases, so there are 2N strobe pulses. `done` is raised in the same cycle as the last response.
- R5: The block rejects a command at acceptance when its offset is above `MAX_OFFSET` (0x201F). For a read it also rejects a count of 0, a count above `MAX_COUNT` (0x42), and a last offset above 0x201F. A rejected command gives one `err` pulse with `err_offset` = `cmd_base`, no strobe, and `busy` stays low.
- R6: A write ignores `cmd_count`. A write with count 0 is accepted and performed.
- R7: If the acknowledge does not reach the awaited level within `TIMEOUT` cycles, the strobe is released after being high for exactly `TIMEOUT` cycles. One `err` pulse follows, with `err_offset` equal to the offset being handled. No further response or phase of that command follows.
- R8: `busy` rises only in the cycle after a command is presented. It stays high until completion. A command presented while `busy` is high is ignored.
- R9: During and after reset, all strobes, `busy`, `done`, `err` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_write | input | 1 | 1 = single write, 0 = burst read |
| cmd_base | input | PORT_W | Register offset, or first offset of a burst |
| cmd_count | input | CNT_W | Number of registers to read |
| cmd_wdata | input | PORT_W | Data for a write |
| cr_dout | output | PORT_W | Offset or write data toward the target |
| cr_cap_addr | output | 1 | Offset capture strobe |
| cr_cap_data | output | 1 | Data capture strobe |
| cr_write | output | 1 | Commit-write strobe |
| cr_read | output | 1 | Read strobe |
| cr_ack | input | 1 | Target acknowledge (asynchronous) |
| cr_din | input | PORT_W | Read data from the target |
| rsp_valid | output | 1 | One read word available |
| rsp_data | output | PORT_W | Read word |
| rsp_offset | output | PORT_W | Offset of the read word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection or timeout pulse |
| err_offset | output | PORT_W | Offset tied to the error |

## Verification
The properties take for granted that the target never raises its acknowledge while every strobe is low. They also assume `cr_din` is stable while the acknowledge is high. The bench's target model answers every strobe after a fixed delay and lowers the acknowledge only once the strobe is gone. The target holds the read word from the rising edge of the acknowledge onward. Its fault modes (acknowledge never rising, acknowledge stuck high, refusal at one offset) only withhold edges. They never create one out of turn, so the timeout cases stay inside these assumptions too.

// File: rtl/crport_pkg.sv
package crport_pkg;
  // Phase code doubles as the index of the strobe it raises.
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_COMMIT = 2'd2,
    PH_READ   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_HIGH = 2'd1,
    HS_LOW  = 2'd2
  } hs_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_LAUNCH = 2'd1,
    SQ_WAIT   = 2'd2
  } sq_state_e;
endpackage

// File: rtl/crport_sync.sv
module crport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/crport_phase.sv
module crport_phase
  import crport_pkg::*;
#(
  parameter int PORT_W  = 16,
  parameter int TIMEOUT = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  phase_e            kind,
  input  logic              ack_s,
  input  logic [PORT_W-1:0] din,
  output logic [3:0]        strobe,
  output logic              fin,
  output logic              tmo,
  output logic [PORT_W-1:0] rdata
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  hs_state_e         st, st_n;
  phase_e            kind_q;
  logic              kind_en;
  logic [TMR_W-1:0]  tmr, tmr_n;
  logic              fin_n, tmo_n;
  logic              rdata_en;
  logic              expired;

  assign expired = (tmr == TMR_LAST);

  always_comb begin
    st_n     = st;
    tmr_n    = tmr;
    fin_n    = 1'b0;
    tmo_n    = 1'b0;
    kind_en  = 1'b0;
    rdata_en = 1'b0;
    unique case (st)
      HS_IDLE: begin
        if (start) begin
          st_n    = HS_HIGH;
          tmr_n   = '0;
          kind_en = 1'b1;
        end
      end
      HS_HIGH: begin
        if (ack_s) begin
          st_n     = HS_LOW;
          tmr_n    = '0;
          rdata_en = (kind_q == PH_READ);
        end else if (expired) begin
          st_n  = HS_IDLE;
          tmo_n = 1'b1;
        end else begin
          tmr_n = tmr + TMR_W'(1);
        end
      end
      HS_LOW: begin
        if (!ack_s) begin
          st_n  = HS_IDLE;
          fin_n = 1'b1;
        end else if (expired) begin
          st_n  = HS_IDLE;
          tmo_n = 1'b1;
        end else begin
          tmr_n = tmr + TMR_W'(1);
        end
      end
      default: st_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= HS_IDLE;
      tmr <= '0;
      fin <= 1'b0;
      tmo <= 1'b0;
    end else begin
      st  <= st_n;
      tmr <= tmr_n;
      fin <= fin_n;
      tmo <= tmo_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kind_q <= PH_ADDR;
    else if (kind_en) kind_q <= kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rdata_en) rdata <= din;
  end

  assign strobe = (st == HS_HIGH) ? (4'd1 << kind_q) : 4'd0;
endmodule

// File: rtl/crport_seq.sv
module crport_seq
  import crport_pkg::*;
#(
  parameter int PORT_W      = 16,
  parameter int CNT_W       = 8,
  parameter int MAX_COUNT   = 66,
  parameter int MAX_OFFSET  = 'h201F,
  parameter int TIMEOUT     = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [PORT_W-1:0] cmd_base,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [PORT_W-1:0] cmd_wdata,
  output logic [PORT_W-1:0] cr_dout,
  output logic              cr_cap_addr,
  output logic              cr_cap_data,
  output logic              cr_write,
  output logic              cr_read,
  input  logic              cr_ack,
  input  logic [PORT_W-1:0] cr_din,
  output logic              rsp_valid,
  output logic [PORT_W-1:0] rsp_data,
  output logic [PORT_W-1:0] rsp_offset,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [PORT_W-1:0] err_offset
);
  localparam int EXT_W = PORT_W + 1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_COUNT);
  localparam logic [EXT_W-1:0] OFF_LIM = EXT_W'(MAX_OFFSET);

  // Acknowledge synchronizer
  logic ack_s;
  crport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cr_ack), .q(ack_s)
  );

  // One handshake phase at a time
  logic              ph_start;
  phase_e            ph, ph_n;
  logic [3:0]        ph_stb;
  logic              ph_fin, ph_tmo;
  logic [PORT_W-1:0] ph_rdata;

  crport_phase #(.PORT_W(PORT_W), .TIMEOUT(TIMEOUT)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(ph_start), .kind(ph),
    .ack_s(ack_s), .din(cr_din), .strobe(ph_stb),
    .fin(ph_fin), .tmo(ph_tmo), .rdata(ph_rdata)
  );

  // Command legality
  logic [EXT_W-1:0] last_off;
  logic             bad_cmd;
  always_comb begin
    last_off = {1'b0, cmd_base} + EXT_W'(cmd_count) - EXT_W'(1);
    bad_cmd  = ({1'b0, cmd_base} > OFF_LIM);
    if (!cmd_write) begin
      bad_cmd = bad_cmd || (cmd_count == '0) || (cmd_count > CNT_LIM)
                        || (last_off > OFF_LIM);
    end
  end

  // Sequencer state
  sq_state_e         sq, sq_n;
  logic [PORT_W-1:0] off_q, off_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [PORT_W-1:0] wdata_q;
  logic              is_wr;
  logic              cmd_ld;
  logic              rsp_ld;
  logic              done_n, err_n, err_ld;
  logic [PORT_W-1:0] err_off_n;

  always_comb begin
    sq_n      = sq;
    ph_n      = ph;
    off_n     = off_q;
    left_n    = left_q;
    cmd_ld    = 1'b0;
    rsp_ld    = 1'b0;
    ph_start  = 1'b0;
    done_n    = 1'b0;
    err_n     = 1'b0;
    err_ld    = 1'b0;
    err_off_n = off_q;
    unique case (sq)
      SQ_IDLE: begin
        if (cmd_valid) begin
          if (bad_cmd) begin
            err_n     = 1'b1;
            err_ld    = 1'b1;
            err_off_n = cmd_base;
          end else begin
            cmd_ld = 1'b1;
            off_n  = cmd_base;
            left_n = cmd_write ? CNT_W'(1) : cmd_count;
            ph_n   = PH_ADDR;
            sq_n   = SQ_LAUNCH;
          end
        end
      end
      SQ_LAUNCH: begin
        ph_start = 1'b1;
        sq_n     = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (ph_tmo) begin
          err_n  = 1'b1;
          err_ld = 1'b1;
          sq_n   = SQ_IDLE;
        end else if (ph_fin) begin
          unique case (ph)
            PH_ADDR: begin
              ph_n = is_wr ? PH_DATA : PH_READ;
              sq_n = SQ_LAUNCH;
            end
            PH_DATA: begin
              ph_n = PH_COMMIT;
              sq_n = SQ_LAUNCH;
            end
            PH_COMMIT: begin
              done_n = 1'b1;
              sq_n   = SQ_IDLE;
            end
            PH_READ: begin
              rsp_ld = 1'b1;
              if (left_q == CNT_W'(1)) begin
                done_n = 1'b1;
                sq_n   = SQ_IDLE;
              end else begin
                off_n  = off_q + PORT_W'(1);
                left_n = left_q - CNT_W'(1);
                ph_n   = PH_ADDR;
                sq_n   = SQ_LAUNCH;
              end
            end
            default: sq_n = SQ_IDLE;
          endcase
        end
      end
      default: sq_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq     <= SQ_IDLE;
      ph     <= PH_ADDR;
      off_q  <= '0;
      left_q <= CNT_W'(1);
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      sq     <= sq_n;
      ph     <= ph_n;
      off_q  <= off_n;
      left_q <= left_n;
      done   <= done_n;
      err    <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      is_wr   <= 1'b0;
    end else if (cmd_ld) begin
      wdata_q <= cmd_wdata;
      is_wr   <= cmd_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= rsp_ld;
      if (rsp_ld) begin
        rsp_data   <= ph_rdata;
        rsp_offset <= off_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_offset <= '0;
    else if (err_ld) err_offset <= err_off_n;
  end

  assign busy        = (sq != SQ_IDLE);
  assign cr_dout     = (ph == PH_ADDR) ? off_q : wdata_q;
  assign cr_cap_addr = ph_stb[PH_ADDR];
  assign cr_cap_data = ph_stb[PH_DATA];
  assign cr_write    = ph_stb[PH_COMMIT];
  assign cr_read     = ph_stb[PH_READ];
endmodule

// File: rtl/crport_seq_chk.sv
module crport_seq_chk #(
  parameter int PORT_W     = 16,
  parameter int MAX_OFFSET = 'h201F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cr_cap_addr,
  input logic              cr_cap_data,
  input logic              cr_write,
  input logic              cr_read,
  input logic              ack_s,
  input logic              ph_tmo,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rsp_valid,
  input logic [PORT_W-1:0] rsp_offset
);
  logic any_stb;
  assign any_stb = cr_cap_addr | cr_cap_data | cr_write | cr_read;

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cr_read, cr_write, cr_cap_data, cr_cap_addr}));

  // R1: a strobe only drops after the synchronized ack was high, or on timeout
  p_drop_after_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_stb) |-> ($past(ack_s) || ph_tmo));

  // R5 and R9: nothing on the port while idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !any_stb);

  p_end_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  p_busy_from_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  p_rsp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_offset <= PORT_W'(MAX_OFFSET)));
endmodule

bind crport_seq crport_seq_chk #(.PORT_W(PORT_W), .MAX_OFFSET(MAX_OFFSET)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
  .cr_write(cr_write), .cr_read(cr_read),
  .ack_s(ack_s), .ph_tmo(ph_tmo), .busy(busy), .done(done), .err(err),
  .rsp_valid(rsp_valid), .rsp_offset(rsp_offset)
);

// File: tb/test_crport_seq.sv
`timescale 1ns/1ps
module test_crport_seq;
  localparam int TO = 40;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_write;
  logic [15:0] cmd_base, cmd_wdata;
  logic [7:0]  cmd_count;
  logic [15:0] cr_dout, cr_din;
  logic        cr_cap_addr, cr_cap_data, cr_write, cr_read, cr_ack;
  logic        rsp_valid, busy, done, err;
  logic [15:0] rsp_data, rsp_offset, err_offset;

  crport_seq #(.TIMEOUT(TO)) i_crport_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_base(cmd_base), .cmd_count(cmd_count), .cmd_wdata(cmd_wdata),
    .cr_dout(cr_dout), .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
    .cr_write(cr_write), .cr_read(cr_read), .cr_ack(cr_ack), .cr_din(cr_din),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_offset(rsp_offset),
    .busy(busy), .done(done), .err(err), .err_offset(err_offset)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] reg_val(input logic [15:0] o);
    return {o[7:0], o[15:8]} ^ 16'h3C5A;
  endfunction

  // Target model: acks after a delay; mode 1 never raises ack,
  // mode 2 never lowers it, mode 3 refuses the offset phase at fail_off.
  int          tmode;
  logic [15:0] fail_off;
  logic [1:0]  t_cnt;
  logic        t_prev;
  logic [15:0] t_addr, t_data, t_wr_addr, t_wr_data;
  int          t_wr_n, t_events;
  logic [5:0]  t_seq;
  logic        any_stb, rise_ok;
  logic [1:0]  code;

  assign any_stb = cr_cap_addr | cr_cap_data | cr_write | cr_read;
  assign code    = cr_read ? 2'd3 : cr_write ? 2'd2 : cr_cap_data ? 2'd1 : 2'd0;
  assign rise_ok = (tmode != 1) && !(tmode == 3 && cr_cap_addr && cr_dout == fail_off);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt <= 2'd0; t_prev <= 1'b0; cr_ack <= 1'b0; cr_din <= 16'h0;
      t_addr <= 16'h0; t_data <= 16'h0; t_wr_addr <= 16'h0; t_wr_data <= 16'h0;
      t_wr_n <= 0; t_events <= 0; t_seq <= 6'h0;
    end else begin
      t_prev <= any_stb;
      if (any_stb && !t_prev) begin
        t_events <= t_events + 1;
        t_seq    <= {t_seq[3:0], code};
      end
      if (any_stb && !cr_ack) begin
        if (t_cnt == 2'd2) begin
          t_cnt <= 2'd0;
          if (rise_ok) begin
            cr_ack <= 1'b1;
            if (cr_cap_addr) t_addr <= cr_dout;
            if (cr_cap_data) t_data <= cr_dout;
            if (cr_write) begin
              t_wr_addr <= t_addr; t_wr_data <= t_data; t_wr_n <= t_wr_n + 1;
            end
            if (cr_read) cr_din <= reg_val(t_addr);
          end
        end else t_cnt <= t_cnt + 2'd1;
      end else if (!any_stb && cr_ack) begin
        if (t_cnt == 2'd2) begin
          t_cnt <= 2'd0;
          if (tmode != 2) cr_ack <= 1'b0;
        end else t_cnt <= t_cnt + 2'd1;
      end else t_cnt <= 2'd0;
    end
  end

  // Output monitor, sampled at the falling edge
  logic [15:0] m_off [256];
  logic [15:0] m_dat [256];
  int m_rsp_n, m_done_n, m_err_n, m_busy_n, m_done_rsp_n, m_run, m_last_run;
  logic [15:0] m_err_off;
  initial begin
    m_rsp_n = 0; m_done_n = 0; m_err_n = 0; m_busy_n = 0;
    m_done_rsp_n = 0; m_run = 0; m_last_run = 0; m_err_off = 16'h0;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        m_off[m_rsp_n[7:0]] = rsp_offset;
        m_dat[m_rsp_n[7:0]] = rsp_data;
        m_rsp_n++;
      end
      if (done) m_done_n++;
      if (done && rsp_valid) m_done_rsp_n++;
      if (err) begin m_err_n++; m_err_off = err_offset; end
      if (busy) m_busy_n++;
      if (any_stb) m_run++;
      else if (m_run > 0) begin m_last_run = m_run; m_run = 0; end
    end
  end

  int n_chk, n_fail;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [15:0] base,
                       input logic [7:0] cnt, input logic [15:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_base = base; cmd_count = cnt; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end(input int d0, input int e0);
    for (int k = 0; k < 6000 && m_done_n == d0 && m_err_n == e0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input logic wr, input logic [15:0] base, input logic [7:0] cnt,
                         input logic [15:0] wd, input logic rej);
    int r0, d0, e0, b0, w0, ev0, dr0;
    r0 = m_rsp_n; d0 = m_done_n; e0 = m_err_n; b0 = m_busy_n;
    w0 = t_wr_n; ev0 = t_events; dr0 = m_done_rsp_n;
    issue(wr, base, cnt, wd);
    wait_end(d0, e0);
    if (rej) begin
      chk("R5 err pulse", m_err_n - e0, 1);
      chk("R5 err_offset", m_err_off, base);
      chk("R5 no strobe", t_events - ev0, 0);
      chk("R5 busy low", m_busy_n - b0, 0);
      chk("R5 no done", m_done_n - d0, 0);
    end else begin
      chk("R2/R4 done pulse", m_done_n - d0, 1);
      chk("R2/R4 no err", m_err_n - e0, 0);
      if (wr) begin
        chk("R2 one write", t_wr_n - w0, 1);
        chk("R2 write offset", t_wr_addr, base);
        chk("R2 write data", t_wr_data, wd);
        chk("R2 phase order", t_seq, 6'b000110);
      end else begin
        chk("R4 response count", m_rsp_n - r0, cnt);
        chk("R4 strobe pulses", t_events - ev0, 2 * cnt);
        chk("R4 done with last", m_done_rsp_n - dr0, 1);
        chk("R3 phase order", t_seq[3:0], 4'b0011);
        chk("R3 no write", t_wr_n - w0, 0);
        for (int i = 0; i < int'(cnt); i++) begin
          chk("R4 offset", m_off[8'(r0 + i)], base + 16'(i));
          chk("R3 data", m_dat[8'(r0 + i)], reg_val(base + 16'(i)));
        end
      end
    end
  endtask

  // {write, base, count, wdata, reject}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 16'h0010, 8'd1,  16'h0000, 1'b0},
    {1'b0, 16'h0100, 8'd4,  16'h0000, 1'b0},
    {1'b1, 16'h0123, 8'd1,  16'hBEEF, 1'b0},
    {1'b0, 16'h201F, 8'd1,  16'h0000, 1'b0},
    {1'b0, 16'h2000, 8'h20, 16'h0000, 1'b0},
    {1'b0, 16'h0000, 8'd0,  16'h0000, 1'b1},
    {1'b0, 16'h0000, 8'h43, 16'h0000, 1'b1},
    {1'b0, 16'h2020, 8'd1,  16'h0000, 1'b1},
    {1'b0, 16'h2010, 8'h11, 16'h0000, 1'b1},
    {1'b1, 16'h201F, 8'd0,  16'h1234, 1'b0},  // R6: count ignored by a write
    {1'b1, 16'h2020, 8'd1,  16'h5555, 1'b1},
    {1'b0, 16'h0040, 8'h42, 16'h0000, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; tmode = 0; fail_off = 16'h0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_base = 16'h0; cmd_count = 8'h0; cmd_wdata = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 strobes in reset", {28'h0, cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
    chk("R9 flags in reset", {28'h0, busy, done, err, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 strobes after reset", {28'h0, cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
    chk("R9 flags after reset", {28'h0, busy, done, err, rsp_valid}, 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][41], VEC[v][40:25], VEC[v][24:17], VEC[v][16:1], VEC[v][0]);

    // R8: busy after accept; command while busy is ignored
    begin
      int r0, d0, e0, w0;
      r0 = m_rsp_n; d0 = m_done_n; e0 = m_err_n; w0 = t_wr_n;
      issue(1'b0, 16'h0200, 8'd3, 16'h0);
      chk("R8 busy after accept", {31'h0, busy}, 1);
      repeat (3) @(negedge clk);
      chk("R8 busy during run", {31'h0, busy}, 1);
      issue(1'b1, 16'h0300, 8'd1, 16'hAAAA);
      wait_end(d0, e0);
      chk("R8 responses of first command only", m_rsp_n - r0, 3);
      chk("R8 last offset", m_off[8'(r0 + 2)], 16'h0202);
      chk("R8 ignored write", t_wr_n - w0, 0);
      chk("R8 busy low at end", {31'h0, busy}, 0);
    end

    // R7: ack never rises
    begin
      int d0, e0, w0;
      d0 = m_done_n; e0 = m_err_n; w0 = t_wr_n;
      tmode = 1;
      issue(1'b1, 16'h0055, 8'd1, 16'h7777);
      wait_end(d0, e0);
      chk("R7 err on rise timeout", m_err_n - e0, 1);
      chk("R7 err_offset", m_err_off, 16'h0055);
      chk("R7 strobe length", m_last_run, TO);
      chk("R7 strobes released", {28'h0, cr_read, cr_write, cr_cap_data, cr_cap_addr}, 0);
      chk("R7 no write", t_wr_n - w0, 0);
      chk("R7 no done", m_done_n - d0, 0);
      tmode = 0;
      repeat (5) @(negedge clk);
    end

    // R7: ack stuck high
    begin
      int r0, d0, e0;
      r0 = m_rsp_n; d0 = m_done_n; e0 = m_err_n;
      tmode = 2;
      issue(1'b0, 16'h0077, 8'd2, 16'h0);
      wait_end(d0, e0);
      chk("R7 err on fall timeout", m_err_n - e0, 1);
      chk("R7 fall err_offset", m_err_off, 16'h0077);
      chk("R7 no response", m_rsp_n - r0, 0);
      tmode = 0;
      repeat (10) @(negedge clk);
    end

    // R7: refusal mid-burst abandons the rest
    begin
      int r0, d0, e0;
      r0 = m_rsp_n; d0 = m_done_n; e0 = m_err_n;
      tmode = 3; fail_off = 16'h0102;
      issue(1'b0, 16'h0100, 8'd5, 16'h0);
      wait_end(d0, e0);
      repeat (20) @(negedge clk);
      chk("R7 burst err", m_err_n - e0, 1);
      chk("R7 burst err_offset", m_err_off, 16'h0102);
      chk("R7 partial responses", m_rsp_n - r0, 2);
      chk("R7 no done", m_done_n - d0, 0);
      tmode = 0;
      repeat (5) @(negedge clk);
    end

    // Sequencer recovers after errors
    run_vec(1'b0, 16'h0005, 8'd2, 16'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule